// File: doc/BRIEF.md
# Load-Store Ordering Checker

This block tracks every in-flight load and store in program order and decides, cycle by cycle, whether a load may run ahead of the stores allocated before it. Each instruction takes a slot in a 16-entry circular queue when it is allocated. A store then reports its address in one step and, later, that its data has been written. A load asks for permission to issue by giving its slot and its address. Entries leave from the oldest end when the surrounding pipeline commits them, and a flush empties the queue in one cycle.

Two policies are selectable with `spec_mode`. In the safe policy, a load waits until every older store has a known address and none of those addresses matches its own. In the speculative policy, a load may go before older store addresses are known. When such a store later reports an address equal to that of a load that already issued, the block raises a squash that names the oldest offending load. Everything from that slot onward is discarded. The load's instruction address also sets a bit in a 64-entry store-wait table. A load whose bit is set is held until all older stores have written their data. A free-running counter wipes the whole table at a fixed period.

Addresses are compared on their low 12 bits only, so the caller supplies just those bits, and two addresses that agree there count as a conflict. The control FSM has three states. `S_EMPTY` means no entries are held. `S_BUSY` means at least one entry is held. `S_SQUASH` is the single cycle in which the squash is presented. The transitions are:
- `flush` goes to `S_EMPTY` from any state.
- A detected conflict goes from `S_EMPTY` or `S_BUSY` to `S_SQUASH`.
- `S_SQUASH` goes to `S_BUSY`, or to `S_EMPTY` when nothing is left.
- Allocation goes from `S_EMPTY` to `S_BUSY`.
- A commit that takes out the last entry goes from `S_BUSY` to `S_EMPTY`.

Top module: `lso_order_chk`

## Requirements
- R1: After reset or after a cycle with `flush` high, `alloc_ready` is 1, `alloc_idx` is 0, `squash_valid` is 0 and `ld_grant` is 0.
- R2: Allocation hands out slots in program order. `alloc_idx` names the slot that the next allocation takes, and it rises by one (mod 16) per accepted allocation. `alloc_ready` is 0 while 16 entries are held.
- R3: A commit (`commit_valid` with at least one entry held) frees the oldest slot, so a full queue accepts one allocation again in the next cycle.
- R4: With `spec_mode`=0, `ld_grant` is 1 only if every older store has reported its address and none of those addresses equals the load's 12-bit address. Any equal older address, or any older address not yet reported, gives 0.
- R5: With `spec_mode`=1, a load whose store-wait bit is clear is granted even when older store addresses are unknown. It is held only by an older store whose reported address equals its own.
- R6: When a store reports an address equal to that of a younger load already granted, `squash_valid` is 1 in the next cycle for exactly one cycle. `squash_idx` names the oldest such load, and `alloc_idx` equals `squash_idx` in that cycle.
- R7: In the cycle with `squash_valid`=1, both `alloc_ready` and `ld_grant` are 0, and an allocation request is not accepted.
- R8: A squash sets the store-wait bit indexed by the 6-bit `alloc_pc_idx` of the squashed load. With `spec_mode`=1, a load whose bit is set is held until every older store has signalled data written.
- R9: All store-wait bits are cleared whenever the free-running counter completes a period of `CLR_PERIOD` cycles.
- R10: Stores younger than the load do not hold it, and a load that has already been granted is not granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_mode | input | 1 | 1 selects the speculative policy, 0 the safe policy |
| flush | input | 1 | Empties the queue |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | 1 when the allocated instruction is a store |
| alloc_pc_idx | input | 6 | Low instruction-address bits used to index the store-wait table |
| alloc_ready | output | 1 | The queue can take an allocation this cycle |
| alloc_idx | output | 4 | Slot given to the next allocation |
| sta_valid | input | 1 | A store reports its address |
| sta_idx | input | 4 | Slot of that store |
| sta_addr | input | 12 | Low address bits of that store |
| std_valid | input | 1 | A store has written its data |
| std_idx | input | 4 | Slot of that store |
| ld_valid | input | 1 | A load asks to issue |
| ld_idx | input | 4 | Slot of that load |
| ld_addr | input | 12 | Low address bits of that load |
| ld_grant | output | 1 | The load may issue (same cycle) |
| commit_valid | input | 1 | Retire the oldest entry |
| squash_valid | output | 1 | Squash the named load and everything younger |
| squash_idx | output | 4 | Slot of the squashed load |

## Verification
The safe policy is swept over 16 store/load address pairs. Some pairs agree in all 12 bits and others differ in a single low bit, which separates an exact-match comparator from one that ignores low bits, and each pair is queried both before and after the store address is known. The speculative policy is tried with an unknown older store, a known non-matching store and a known matching store. A conflict with two younger granted loads shows whether the oldest one is chosen and whether the tail is cut back. The store-wait path is checked with the same instruction address before and after the data write, with a different address that must stay unaffected, and once more after a full clear period.

// File: rtl/lso_pkg.sv
package lso_pkg;
    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_BUSY   = 2'd1,
        S_SQUASH = 2'd2
    } lso_state_e;
endpackage

// File: rtl/lso_wait_table.sv
module lso_wait_table #(
    parameter int ENTRIES    = 64,
    parameter int CLR_PERIOD = 4096,
    localparam int IX_W      = $clog2(ENTRIES),
    localparam int CNT_W     = $clog2(CLR_PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IX_W-1:0] set_ix,
    input  logic [IX_W-1:0] rd_ix,
    output logic            rd_bit
);
    logic [ENTRIES-1:0] bits_q;
    logic [CNT_W-1:0]   tick_q;
    logic               wipe;

    assign wipe   = (tick_q == CNT_W'(CLR_PERIOD - 1));
    assign rd_bit = bits_q[rd_ix];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            bits_q <= '0;
        end else begin
            tick_q <= wipe ? '0 : tick_q + CNT_W'(1);
            if (wipe)
                bits_q <= '0;
            else if (set_en)
                bits_q[set_ix] <= 1'b1;
        end
    end
endmodule

// File: rtl/lso_issue_check.sv
module lso_issue_check #(
    parameter int DEPTH = 16,
    parameter int CMP_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            ent_v,
    input  logic [DEPTH-1:0]            ent_st,
    input  logic [DEPTH-1:0]            ent_known,
    input  logic [DEPTH-1:0]            ent_done,
    input  logic [DEPTH-1:0][CMP_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][IDX_W-1:0] ent_rel,
    input  logic [IDX_W-1:0]            q_rel,
    input  logic [CMP_W-1:0]            q_addr,
    input  logic                        spec,
    input  logic                        wait_bit,
    output logic                        blocked
);
    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i] && ent_st[i] && (ent_rel[i] < q_rel)) begin
                if (!spec)
                    blocked = blocked | !ent_known[i] | (ent_addr[i] == q_addr);
                else if (wait_bit)
                    blocked = blocked | !ent_done[i];
                else
                    blocked = blocked | (ent_known[i] && (ent_addr[i] == q_addr));
            end
        end
    end
endmodule

// File: rtl/lso_conflict_scan.sv
module lso_conflict_scan #(
    parameter int DEPTH = 16,
    parameter int CMP_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            ent_v,
    input  logic [DEPTH-1:0]            ent_st,
    input  logic [DEPTH-1:0]            ent_iss,
    input  logic [DEPTH-1:0][CMP_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][IDX_W-1:0] ent_rel,
    input  logic [IDX_W-1:0]            s_rel,
    input  logic [CMP_W-1:0]            s_addr,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [IDX_W-1:0] best_rel;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        best_rel = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i] && !ent_st[i] && ent_iss[i] && (ent_rel[i] > s_rel) &&
                (ent_addr[i] == s_addr) && (!hit || ent_rel[i] < best_rel)) begin
                hit      = 1'b1;
                hit_idx  = IDX_W'(i);
                best_rel = ent_rel[i];
            end
        end
    end
endmodule

// File: rtl/lso_order_chk.sv
module lso_order_chk
    import lso_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int CMP_W      = 12,
    parameter int WT_ENTRIES = 64,
    parameter int CLR_PERIOD = 4096,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int WT_W      = $clog2(WT_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spec_mode,
    input  logic             flush,
    input  logic             alloc_valid,
    input  logic             alloc_is_store,
    input  logic [WT_W-1:0]  alloc_pc_idx,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             sta_valid,
    input  logic [IDX_W-1:0] sta_idx,
    input  logic [CMP_W-1:0] sta_addr,
    input  logic             std_valid,
    input  logic [IDX_W-1:0] std_idx,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [CMP_W-1:0] ld_addr,
    output logic             ld_grant,
    input  logic             commit_valid,
    output logic             squash_valid,
    output logic [IDX_W-1:0] squash_idx
);
    lso_state_e state_q, state_d;

    logic [IDX_W:0]              head_q, tail_q, head_d, tail_d, count;
    logic [DEPTH-1:0]            e_st, e_known, e_done, e_iss, e_v, scan_iss;
    logic [DEPTH-1:0][CMP_W-1:0] e_addr, scan_addr;
    logic [DEPTH-1:0][IDX_W-1:0] e_rel;
    logic [WT_W-1:0]             e_pcix [DEPTH];
    logic [IDX_W-1:0]            sq_q;
    logic                        live, full, alloc_fire, commit_fire, sta_fire;
    logic                        blocked, wait_bit, conflict_hit;
    logic [IDX_W-1:0]            hit_idx;

    assign count = tail_q - head_q;
    assign full  = (count == (IDX_W + 1)'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign e_rel[g]     = IDX_W'(g) - head_q[IDX_W-1:0];
        assign e_v[g]       = ({1'b0, e_rel[g]} < count);
        assign scan_iss[g]  = e_iss[g] | (ld_grant && ld_idx == IDX_W'(g));
        assign scan_addr[g] = (ld_grant && ld_idx == IDX_W'(g)) ? ld_addr : e_addr[g];
    end

    // outputs and handshakes
    always_comb begin
        live         = (state_q != S_SQUASH) && !flush;
        alloc_ready  = (state_q != S_SQUASH) && !full;
        squash_valid = (state_q == S_SQUASH);
        squash_idx   = sq_q;
        alloc_idx    = tail_q[IDX_W-1:0];
        alloc_fire   = alloc_valid && alloc_ready;
        commit_fire  = commit_valid && live && (count != '0);
        sta_fire     = sta_valid && live && e_v[sta_idx] && e_st[sta_idx];
        ld_grant     = ld_valid && live && e_v[ld_idx] && !e_st[ld_idx] &&
                       !e_iss[ld_idx] && !blocked;
        conflict_hit = sta_fire && hit_flag;
    end

    logic hit_flag;

    lso_issue_check #(.DEPTH(DEPTH), .CMP_W(CMP_W)) u_issue (
        .ent_v(e_v), .ent_st(e_st), .ent_known(e_known), .ent_done(e_done),
        .ent_addr(e_addr), .ent_rel(e_rel), .q_rel(e_rel[ld_idx]),
        .q_addr(ld_addr), .spec(spec_mode), .wait_bit(wait_bit),
        .blocked(blocked)
    );

    lso_conflict_scan #(.DEPTH(DEPTH), .CMP_W(CMP_W)) u_scan (
        .ent_v(e_v), .ent_st(e_st), .ent_iss(scan_iss), .ent_addr(scan_addr),
        .ent_rel(e_rel), .s_rel(e_rel[sta_idx]), .s_addr(sta_addr),
        .hit(hit_flag), .hit_idx(hit_idx)
    );

    lso_wait_table #(.ENTRIES(WT_ENTRIES), .CLR_PERIOD(CLR_PERIOD)) u_wait (
        .clk(clk), .rst_n(rst_n), .set_en(conflict_hit),
        .set_ix(e_pcix[hit_idx]), .rd_ix(e_pcix[ld_idx]), .rd_bit(wait_bit)
    );

    // pointer and next-state computation
    always_comb begin
        head_d  = head_q;
        tail_d  = tail_q;
        state_d = state_q;
        if (flush) begin
            head_d = '0;
            tail_d = '0;
        end else begin
            if (commit_fire)
                head_d = head_q + (IDX_W + 1)'(1);
            if (conflict_hit)
                tail_d = head_q + {1'b0, e_rel[hit_idx]};
            else if (alloc_fire)
                tail_d = tail_q + (IDX_W + 1)'(1);
        end
        unique case (state_q)
            S_EMPTY, S_BUSY: begin
                if (flush)             state_d = S_EMPTY;
                else if (conflict_hit) state_d = S_SQUASH;
                else if (tail_d == head_d) state_d = S_EMPTY;
                else                   state_d = S_BUSY;
            end
            S_SQUASH: begin
                if (flush || tail_d == head_d) state_d = S_EMPTY;
                else                           state_d = S_BUSY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            sq_q    <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
            if (conflict_hit)
                sq_q <= hit_idx;
        end
    end

    // entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_st    <= '0;
            e_known <= '0;
            e_done  <= '0;
            e_iss   <= '0;
            e_addr  <= '0;
            for (int i = 0; i < DEPTH; i++) e_pcix[i] <= '0;
        end else begin
            if (alloc_fire) begin
                e_st[alloc_idx]    <= alloc_is_store;
                e_known[alloc_idx] <= 1'b0;
                e_done[alloc_idx]  <= 1'b0;
                e_iss[alloc_idx]   <= 1'b0;
                e_pcix[alloc_idx]  <= alloc_pc_idx;
            end
            if (sta_fire) begin
                e_known[sta_idx] <= 1'b1;
                e_addr[sta_idx]  <= sta_addr;
            end
            if (std_valid && live && e_v[std_idx] && e_st[std_idx])
                e_done[std_idx] <= 1'b1;
            if (ld_grant) begin
                e_iss[ld_idx]  <= 1'b1;
                e_addr[ld_idx] <= ld_addr;
            end
        end
    end
endmodule

// File: rtl/lso_order_sva.sv
module lso_order_sva #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             ld_grant,
    input logic             squash_valid,
    input logic [IDX_W-1:0] squash_idx,
    input logic             conflict_hit
);
    // R6
    squash_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !squash_valid);

    // R6
    squash_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (alloc_idx == squash_idx));

    // R7
    squash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (!ld_grant && !alloc_ready));

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !flush && !conflict_hit) |=>
            (alloc_idx == $past(alloc_idx) + IDX_W'(1)));

    // R1
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (alloc_ready && !squash_valid && alloc_idx == '0));
endmodule

bind lso_order_chk lso_order_sva #(.IDX_W(IDX_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .ld_grant(ld_grant),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .conflict_hit(conflict_hit)
);

// File: tb/sim_lso_order_chk.sv
module sim_lso_order_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spec_mode = 1'b0, flush = 1'b0;
    logic        alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic [5:0]  alloc_pc_idx = '0;
    logic        alloc_ready;
    logic [3:0]  alloc_idx;
    logic        sta_valid = 1'b0;
    logic [3:0]  sta_idx = '0;
    logic [11:0] sta_addr = '0;
    logic        std_valid = 1'b0;
    logic [3:0]  std_idx = '0;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [11:0] ld_addr = '0;
    logic        ld_grant, commit_valid = 1'b0, squash_valid;
    logic [3:0]  squash_idx;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    lso_order_chk #(.CLR_PERIOD(256)) u0 (
        .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_pc_idx(alloc_pc_idx), .alloc_ready(alloc_ready),
        .alloc_idx(alloc_idx), .sta_valid(sta_valid), .sta_idx(sta_idx),
        .sta_addr(sta_addr), .std_valid(std_valid), .std_idx(std_idx),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_addr(ld_addr),
        .ld_grant(ld_grant), .commit_valid(commit_valid),
        .squash_valid(squash_valid), .squash_idx(squash_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic st, input logic [5:0] pc);
        alloc_valid = 1'b1; alloc_is_store = st; alloc_pc_idx = pc;
        cyc();
        alloc_valid = 1'b0;
    endtask

    task automatic do_sta(input logic [3:0] idx, input logic [11:0] a);
        sta_valid = 1'b1; sta_idx = idx; sta_addr = a;
        cyc();
        sta_valid = 1'b0;
    endtask

    task automatic do_std(input logic [3:0] idx);
        std_valid = 1'b1; std_idx = idx;
        cyc();
        std_valid = 1'b0;
    endtask

    task automatic query(input logic [3:0] idx, input logic [11:0] a,
                         input int exp, input string req);
        ld_valid = 1'b1; ld_idx = idx; ld_addr = a;
        #1;
        chk(req, int'(ld_grant), exp);
        cyc();
        ld_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 ready", int'(alloc_ready), 1);
        chk("R1 idx", int'(alloc_idx), 0);
        chk("R1 squash", int'(squash_valid), 0);
        chk("R1 grant", int'(ld_grant), 0);

        // speculative run with conflict (store slot 0, loads 1 and 2)
        spec_mode = 1'b1;
        do_alloc(1'b1, 6'd0);
        do_alloc(1'b0, 6'd4);
        do_alloc(1'b0, 6'd8);
        query(4'd1, 12'h234, 1, "R5 unknown older store");
        query(4'd2, 12'h800, 1, "R5 second load");
        do_sta(4'd0, 12'h234);
        chk("R6 squash", int'(squash_valid), 1);
        chk("R6 squash idx", int'(squash_idx), 1);
        chk("R6 tail cut", int'(alloc_idx), 1);
        chk("R7 ready low", int'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_is_store = 1'b0; alloc_pc_idx = 6'd9;
        ld_valid = 1'b1; ld_idx = 4'd0; ld_addr = 12'h000;
        #1;
        chk("R7 grant low", int'(ld_grant), 0);
        cyc();
        alloc_valid = 1'b0; ld_valid = 1'b0;
        chk("R6 one cycle", int'(squash_valid), 0);
        chk("R7 alloc ignored", int'(alloc_idx), 1);

        // store-wait behaviour
        do_alloc(1'b0, 6'd4);
        query(4'd1, 12'h500, 0, "R8 wait bit holds");
        do_alloc(1'b0, 6'd8);
        query(4'd2, 12'h500, 1, "R8 other pc free");
        do_std(4'd0);
        query(4'd1, 12'h500, 1, "R8 after data");
        query(4'd1, 12'h500, 0, "R10 no regrant");
        commit_valid = 1'b1;
        cyc(); cyc(); cyc();
        commit_valid = 1'b0;
        chk("R3 drained idx", int'(alloc_idx), 3);
        do_flush();
        chk("R1 flush idx", int'(alloc_idx), 0);

        // clear period
        do_alloc(1'b1, 6'd1);
        do_alloc(1'b0, 6'd4);
        query(4'd1, 12'h100, 0, "R8 bit still set");
        repeat (260) cyc();
        query(4'd1, 12'h100, 1, "R9 bits cleared");

        do_flush();
        do_alloc(1'b1, 6'd1);
        do_sta(4'd0, 12'h0C0);
        do_alloc(1'b0, 6'd2);
        query(4'd1, 12'h0C0, 0, "R5 known match holds");
        query(4'd1, 12'h0C1, 1, "R5 known differ goes");

        // safe policy sweep
        spec_mode = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic [11:0] sa, la;
            sa = 12'h3A0 + 12'(k * 17);
            la = (k % 3 == 0) ? sa : (sa ^ 12'(1 << (k % 12)));
            do_flush();
            do_alloc(1'b1, 6'd10);
            do_alloc(1'b0, 6'd11);
            query(4'd1, la, 0, "R4 unknown store");
            do_sta(4'd0, sa);
            query(4'd1, la, (sa != la) ? 1 : 0, "R4 sweep");
        end

        // younger store does not hold; two older stores
        do_flush();
        do_alloc(1'b0, 6'd12);
        do_alloc(1'b1, 6'd13);
        query(4'd0, 12'h010, 1, "R10 younger store");
        do_flush();
        do_alloc(1'b1, 6'd13);
        do_alloc(1'b1, 6'd14);
        do_alloc(1'b0, 6'd15);
        do_sta(4'd0, 12'h111);
        query(4'd2, 12'h222, 0, "R4 one unknown");
        do_sta(4'd1, 12'h333);
        query(4'd2, 12'h222, 1, "R4 all known");

        // fill and commit
        do_flush();
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", int'(alloc_idx), i);
            do_alloc(1'b1, 6'd20);
        end
        chk("R2 full", int'(alloc_ready), 0);
        commit_valid = 1'b1;
        cyc();
        commit_valid = 1'b0;
        chk("R3 ready again", int'(alloc_ready), 1);
        chk("R3 wrap idx", int'(alloc_idx), 0);

        // oldest of two conflicting loads
        do_flush();
        spec_mode = 1'b1;
        do_alloc(1'b1, 6'd30);
        do_alloc(1'b0, 6'd31);
        do_alloc(1'b0, 6'd32);
        query(4'd1, 12'h0AB, 1, "R5 load a");
        query(4'd2, 12'h0AB, 1, "R5 load b");
        do_sta(4'd0, 12'h0AB);
        chk("R6 oldest idx", int'(squash_idx), 1);
        chk("R6 squash two", int'(squash_valid), 1);
        cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule